// File: doc/BRIEF.md
# ADC power and range sequencer

This block supervises the control pins of an external 14-bit sampling converter. It drives two active-low shutdown pins, one for a light power-down (nap) that keeps the reference alive and one for a deep power-down (sleep), plus the two gain-select pins that pick one of four input spans. A host issues single-cycle requests to enter nap, enter sleep, return to run, or change the input range. The block then keeps `ready_o` low until the converter's wake-up or reference-settling interval has elapsed. Only while `ready_o` is high may the host start conversions.

Every interval is specified in nanoseconds and converted to clock cycles from the `CLK_HZ` parameter. The settling time after a range change depends on both the old and the new range. Stepping up from -3 dB to 0 dB is fast. Stepping down from 0 dB to -3 dB is slower, because the reference capacitor discharges through a weak current. Any move to the two lowest ranges, and every other change, takes the longest wait. Leaving nap costs nanoseconds, while leaving sleep costs hundreds of milliseconds.

Top module: `adc_pwr_seq`

## Requirements
- R1: While `rst_ni` is low, `nap_no` and `sleep_no` are high, `range_o` is 2'b11, `mode_o` is 0 (run) and `ready_o` is low. After release, `ready_o` rises exactly SLEEP_CYC rising clock edges later.
- R2: Each interval T (nap 250 ns, sleep 210 ms, up-step 0.6 ms, down-step 11 ms, low-range 700 ms) lasts ceil(T * CLK_HZ / 1e9) cycles, and never less than one cycle. `ready_o` stays low for exactly that many rising edges after the edge that accepts the request.
- R3: A nap request (`req_op_i` = 1) accepted in run mode drives `nap_no` low, keeps `sleep_no` high, sets `mode_o` to 1 and drops `ready_o` on the next edge.
- R4: A sleep request (`req_op_i` = 2) accepted in any mode drives `sleep_no` low, releases `nap_no` high, sets `mode_o` to 2 and drops `ready_o` on the next edge.
- R5: A nap request made in sleep mode is ignored: the block stays in sleep.
- R6: A run request (`req_op_i` = 0) made in nap mode releases `nap_no` and sets `mode_o` to 0. It starts the nap wake-up wait.
- R7: A run request made in sleep mode releases `sleep_no` and sets `mode_o` to 0. It starts the sleep wake-up wait.
- R8: A range request (`req_op_i` = 3) in run mode loads the code `req_range_i` into `range_o` on the next edge. The pins follow the code as `gain0_o` = code[1] and `gain1_o` = code[0]. Code 11 is 0 dB, 10 is -3 dB, 01 is -6 dB and 00 is -9 dB.
- R9: A change from code 10 to code 11 waits the up-step interval. A change from code 11 to code 10 waits the down-step interval.
- R10: Every other range change, including every change to code 01 or 00, waits the low-range interval.
- R11: The following requests have no effect on any output: a range request equal to the current code, a range request made in nap or sleep, and a run request made in run mode.
- R12: A request accepted while a wait is running restarts the wait with that request's interval, counted from that request. `ready_o` stays low in between.
- R13: `ready_o` is high only in run mode with both shutdown pins high. Once high, it stays high until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one cycle per request |
| req_op_i | input | 2 | Request kind: 0 run, 1 nap, 2 sleep, 3 range |
| req_range_i | input | 2 | Target range code for a range request |
| nap_no | output | 1 | Converter nap pin, active low |
| sleep_no | output | 1 | Converter sleep pin, active low |
| gain0_o | output | 1 | Gain-select pin, range code bit 1 |
| gain1_o | output | 1 | Gain-select pin, range code bit 0 |
| ready_o | output | 1 | High when conversions may start |
| mode_o | output | 2 | Current mode: 0 run, 1 nap, 2 sleep |
| range_o | output | 2 | Current range code |

## Verification
A wrong mode register shows on the shutdown pins and on `mode_o` at the edge after the request. A wrong range register shows on the gain pins at that same edge. A wrong wait selection or a mis-loaded down-counter shows only when `ready_o` rises: it rises a fixed number of cycles early or late, so the bench counts edges from each accepted request until `ready_o` rises. All sixteen ordered pairs of range codes are swept, each checked against an expected count that the bench works out independently. A counter that fails to restart surfaces as a count measured from the earlier request instead of the later one.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    OP_RUN   = 2'd0,
    OP_NAP   = 2'd1,
    OP_SLEEP = 2'd2,
    OP_RANGE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    M_ACTIVE = 2'd0,
    M_NAP    = 2'd1,
    M_SLEEP  = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    W_NAP   = 3'd0,
    W_SLEEP = 3'd1,
    W_UP    = 3'd2,
    W_DOWN  = 3'd3,
    W_LOW   = 3'd4
  } wait_e;

  localparam logic [1:0] RG_0DB  = 2'b11;
  localparam logic [1:0] RG_M3DB = 2'b10;

  // Settling class of a range move: only the two top codes have short waits.
  function automatic wait_e range_wait(logic [1:0] from_rg, logic [1:0] to_rg);
    if (from_rg == RG_M3DB && to_rg == RG_0DB) return W_UP;
    if (from_rg == RG_0DB && to_rg == RG_M3DB) return W_DOWN;
    return W_LOW;
  endfunction

  function automatic longint unsigned ns_to_cycles(longint unsigned hz,
                                                   longint unsigned ns);
    longint unsigned c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    return (c == 0) ? 64'd1 : c;
  endfunction

  function automatic longint unsigned max2(longint unsigned a, longint unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [1:0] req_op_i,
  input  logic [1:0] req_range_i,
  output mode_e      mode_o,
  output logic [1:0] range_o,
  output logic       load_o,
  output wait_e      kind_o
);

  mode_e      mode_q, mode_d;
  logic [1:0] range_q, range_d;
  op_e        op;

  assign op = op_e'(req_op_i);

  always_comb begin
    mode_d  = mode_q;
    range_d = range_q;
    load_o  = 1'b0;
    kind_o  = W_NAP;
    if (req_i) begin
      unique case (op)
        OP_RUN: begin
          if (mode_q == M_NAP) begin
            mode_d = M_ACTIVE;
            load_o = 1'b1;
            kind_o = W_NAP;
          end else if (mode_q == M_SLEEP) begin
            mode_d = M_ACTIVE;
            load_o = 1'b1;
            kind_o = W_SLEEP;
          end
        end
        OP_NAP: begin
          if (mode_q != M_SLEEP) mode_d = M_NAP;  // sleep dominates nap
        end
        OP_SLEEP: mode_d = M_SLEEP;
        OP_RANGE: begin
          if (mode_q == M_ACTIVE && req_range_i != range_q) begin
            range_d = req_range_i;
            load_o  = 1'b1;
            kind_o  = range_wait(range_q, req_range_i);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_ACTIVE;
      range_q <= RG_0DB;
    end else begin
      mode_q  <= mode_d;
      range_q <= range_d;
    end
  end

  assign mode_o  = mode_q;
  assign range_o = range_q;

endmodule

// File: rtl/adc_seq_wait_sel.sv
module adc_seq_wait_sel
  import adc_seq_pkg::*;
#(
  parameter int unsigned     CW      = 8,
  parameter longint unsigned C_NAP   = 1,
  parameter longint unsigned C_SLEEP = 1,
  parameter longint unsigned C_UP    = 1,
  parameter longint unsigned C_DOWN  = 1,
  parameter longint unsigned C_LOW   = 1
) (
  input  wait_e          kind_i,
  output logic [CW-1:0]  cycles_o
);

  always_comb begin
    unique case (kind_i)
      W_NAP:   cycles_o = CW'(C_NAP);
      W_SLEEP: cycles_o = CW'(C_SLEEP);
      W_UP:    cycles_o = CW'(C_UP);
      W_DOWN:  cycles_o = CW'(C_DOWN);
      default: cycles_o = CW'(C_LOW);
    endcase
  end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned          CW        = 8,
  parameter logic [CW-1:0]        RESET_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= RESET_VAL;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 100_000_000,
  parameter longint unsigned NAP_NS   = 250,
  parameter longint unsigned SLEEP_NS = 210_000_000,
  parameter longint unsigned UP_NS    = 600_000,
  parameter longint unsigned DOWN_NS  = 11_000_000,
  parameter longint unsigned LOW_NS   = 700_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [1:0] req_op_i,
  input  logic [1:0] req_range_i,
  output logic       nap_no,
  output logic       sleep_no,
  output logic       gain0_o,
  output logic       gain1_o,
  output logic       ready_o,
  output logic [1:0] mode_o,
  output logic [1:0] range_o
);

  localparam longint unsigned NAP_CYC   = ns_to_cycles(CLK_HZ, NAP_NS);
  localparam longint unsigned SLEEP_CYC = ns_to_cycles(CLK_HZ, SLEEP_NS);
  localparam longint unsigned UP_CYC    = ns_to_cycles(CLK_HZ, UP_NS);
  localparam longint unsigned DOWN_CYC  = ns_to_cycles(CLK_HZ, DOWN_NS);
  localparam longint unsigned LOW_CYC   = ns_to_cycles(CLK_HZ, LOW_NS);
  localparam longint unsigned MAX_CYC   =
    max2(max2(max2(NAP_CYC, SLEEP_CYC), max2(UP_CYC, DOWN_CYC)), LOW_CYC);
  localparam int unsigned     CW        = $clog2(MAX_CYC + 1);

  mode_e         mode;
  logic [1:0]    range_q;
  logic          load;
  wait_e         kind;
  logic [CW-1:0] wait_cyc;
  logic          done;

  adc_seq_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_op_i    (req_op_i),
    .req_range_i (req_range_i),
    .mode_o      (mode),
    .range_o     (range_q),
    .load_o      (load),
    .kind_o      (kind)
  );

  adc_seq_wait_sel #(
    .CW      (CW),
    .C_NAP   (NAP_CYC),
    .C_SLEEP (SLEEP_CYC),
    .C_UP    (UP_CYC),
    .C_DOWN  (DOWN_CYC),
    .C_LOW   (LOW_CYC)
  ) i_wait_sel (
    .kind_i   (kind),
    .cycles_o (wait_cyc)
  );

  // Reset behaves as a release from sleep.
  adc_seq_timer #(
    .CW        (CW),
    .RESET_VAL (CW'(SLEEP_CYC))
  ) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (wait_cyc),
    .done_o (done)
  );

  assign nap_no   = (mode != M_NAP);
  assign sleep_no = (mode != M_SLEEP);
  assign gain0_o  = range_q[1];
  assign gain1_o  = range_q[0];
  assign range_o  = range_q;
  assign mode_o   = mode;
  assign ready_o  = (mode == M_ACTIVE) && done;

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [1:0] req_op_i,
  input logic [1:0] req_range_i,
  input logic       nap_no,
  input logic       sleep_no,
  input logic       ready_o,
  input logic [1:0] mode_o,
  input logic [1:0] range_o
);

  a_r3_nap_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && req_op_i == 2'd1 && mode_o == 2'd0
    |=> !nap_no && sleep_no && mode_o == 2'd1 && !ready_o);

  a_r4_sleep_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && req_op_i == 2'd2
    |=> !sleep_no && nap_no && mode_o == 2'd2 && !ready_o);

  a_r5_nap_in_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && req_op_i == 2'd1 && mode_o == 2'd2
    |=> mode_o == 2'd2 && !sleep_no);

  a_r11_range_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && req_op_i == 2'd3 && mode_o != 2'd0
    |=> $stable(range_o));

  a_r12_range_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && req_op_i == 2'd3 && mode_o == 2'd0 && req_range_i != range_o
    |=> !ready_o && range_o == $past(req_range_i));

  a_r13_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !req_i |=> ready_o);

  a_r13_ready_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> mode_o == 2'd0 && nap_no && sleep_no);

endmodule

bind adc_pwr_seq adc_seq_checker i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .req_op_i    (req_op_i),
  .req_range_i (req_range_i),
  .nap_no      (nap_no),
  .sleep_no    (sleep_no),
  .ready_o     (ready_o),
  .mode_o      (mode_o),
  .range_o     (range_o)
);

// File: tb/test_adc_pwr_seq.sv
module test_adc_pwr_seq;

  localparam int CLK_PERIOD = 10;
  localparam longint unsigned HZ = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [1:0] op = 2'd0;
  logic [1:0] rng = 2'd0;
  logic       nap_n, sleep_n, g0, g1, ready;
  logic [1:0] mode, range_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_f  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_pwr_seq #(.CLK_HZ(HZ)) i_adc_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_op_i(op), .req_range_i(rng),
    .nap_no(nap_n), .sleep_no(sleep_n), .gain0_o(g0), .gain1_o(g1),
    .ready_o(ready), .mode_o(mode), .range_o(range_q)
  );

  function automatic int exp_cyc(longint unsigned ns);
    longint unsigned prod, q;
    prod = HZ * ns;
    q = prod / 1_000_000_000;
    if (q * 1_000_000_000 < prod) q++;
    if (q == 0) q = 1;
    return int'(q);
  endfunction

  function automatic int exp_range(int f, int t);
    if (f == 2 && t == 3) return exp_cyc(600_000);
    if (f == 3 && t == 2) return exp_cyc(11_000_000);
    return exp_cyc(700_000_000);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(logic [1:0] o, logic [1:0] r);
    @(negedge clk);
    req = 1'b1; op = o; rng = r;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic count_ready(output int n);
    n = 0;
    while (!ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done_f) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int sleep_c, nap_c;
    sleep_c = exp_cyc(210_000_000);
    nap_c   = exp_cyc(250);

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(nap_n && sleep_n && mode == 2'd0 && !ready, "R1 pins in reset",
        {nap_n, sleep_n, ready}, 3'b110);
    chk(range_q == 2'b11 && g0 && g1, "R1 range in reset", range_q, 3);
    rst_n = 1'b1;
    count_ready(n);
    chk(n == sleep_c, "R1/R2 wait after reset", n, sleep_c);

    // R8 R9 R10 R11: sweep every ordered pair of range codes
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        send(2'd3, 2'(f));
        count_ready(n);
        send(2'd3, 2'(t));
        if (f == t) begin
          repeat (3) @(negedge clk);
          chk(ready && range_q == 2'(t), "R11 same range ignored", ready, 1);
        end else begin
          chk(range_q == 2'(t) && g0 == t[1] && g1 == t[0], "R8 range pins",
              {g0, g1}, t);
          count_ready(n);
          chk(n == exp_range(f, t), (f + t == 5) ? "R2/R9 up/down wait" : "R2/R10 low wait",
              n, exp_range(f, t));
        end
      end
    end

    // R3, R11, R6: nap, range frozen, wake
    send(2'd1, 2'd0);
    chk(!nap_n && sleep_n && mode == 2'd1 && !ready, "R3 nap entry",
        {nap_n, sleep_n, ready}, 3'b010);
    send(2'd3, 2'd0);
    chk(range_q == 2'd3, "R11 range ignored in nap", range_q, 3);
    send(2'd0, 2'd0);
    chk(nap_n && mode == 2'd0, "R6 nap release", mode, 0);
    count_ready(n);
    chk(n == nap_c, "R2/R6 nap wake wait", n, nap_c);

    // R4, R5, R7
    send(2'd2, 2'd0);
    chk(!sleep_n && nap_n && mode == 2'd2 && !ready, "R4 sleep entry",
        {nap_n, sleep_n, ready}, 3'b100);
    send(2'd1, 2'd0);
    chk(mode == 2'd2 && !sleep_n && nap_n, "R5 nap in sleep ignored", mode, 2);
    send(2'd0, 2'd0);
    chk(sleep_n && mode == 2'd0, "R7 sleep release", mode, 0);
    count_ready(n);
    chk(n == sleep_c, "R2/R7 sleep wake wait", n, sleep_c);

    // R4 from nap
    send(2'd1, 2'd0);
    send(2'd2, 2'd0);
    chk(!sleep_n && nap_n && mode == 2'd2, "R4 sleep from nap", mode, 2);
    send(2'd0, 2'd0);
    count_ready(n);
    chk(n == sleep_c, "R7 wake after nap-to-sleep", n, sleep_c);

    // R12 restart by a range request
    send(2'd3, 2'd2);
    repeat (5) @(negedge clk);
    chk(!ready, "R12 ready low mid-wait", ready, 0);
    send(2'd3, 2'd3);
    count_ready(n);
    chk(n == exp_cyc(600_000), "R12 restart with up-step wait", n, exp_cyc(600_000));

    // R12 restart by nap then run
    send(2'd3, 2'd0);
    repeat (3) @(negedge clk);
    send(2'd1, 2'd0);
    send(2'd0, 2'd0);
    count_ready(n);
    chk(n == nap_c, "R12 restart with nap wake wait", n, nap_c);

    // R11 run while active; R13 ready holds
    send(2'd0, 2'd0);
    chk(ready && mode == 2'd0, "R11 run in run mode ignored", ready, 1);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (ready && nap_n && sleep_n) n++;
    end
    chk(n == 50, "R13 ready holds without requests", n, 50);

    done_f = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule